// File: doc/BRIEF.md
# Shadow-Held Scan Select Decompressor

This block turns a few tester channel bits per shift cycle into one data bit for each scan chain. A linear ring generator takes in the channel bits on every shift cycle. One XOR phase shifter reads the generator state and makes a parent-pattern bit for every chain. A shadow register can take a copy of the generator state. A second XOR phase shifter reads that copy and makes a select bit for every chain. In front of each chain a 2:1 mux then passes either the parent bit or an incremental bit that a separate decompressor supplies.

The shadow register has no load pin of its own. It reloads whenever the parity of the channel bits is 1, taken over the bits injected in the current cycle and the bits kept from the previous shift cycles. The tester can therefore hold the selects steady for many shift cycles while the generator keeps running and collecting variables for later bits. At the start of each pattern, a synchronous clear sets the generator, the shadow copy and the channel history to zero. A shift enable freezes every register during capture cycles.

Top module: `shadow_select_decomp`

## Requirements
- R1: While the asynchronous active-low reset is applied, and right after it is released, `parent_out`, `sel_out` and `scan_out` are all 0.
- R2: On a shift cycle the 32-bit generator state s becomes {s[30:0], f}, where f is the XOR of the state bits selected by the tap mask 32'h8020_0003. Channel bit 0 is then XORed into bit 5 and channel bit 1 into bit 17.
- R3: `parent_out[j]` is the XOR of state bits (5j)%32, (11j+3)%32 and (17j+7)%32. Taps that fall on the same position cancel.
- R4: The reload enable is the XOR of all current channel bits and all channel bits kept from the previous BUF_DEPTH shift cycles. The default BUF_DEPTH is 1.
- R5: On a shift cycle with the enable at 1, the shadow register takes the generator state from before that cycle's advance. From the next cycle on, `sel_out[j]` is the XOR of shadow bits (5j+13)%32, (11j+16)%32 and (17j+20)%32.
- R6: On a shift cycle with the enable at 0, the shadow register and `sel_out` keep their values.
- R7: `scan_out[j]` equals `incr_in[j]` when `sel_out[j]` is 1, and `parent_out[j]` when it is 0.
- R8: With `shift_en` low and `clr` low, the generator, the shadow register and the channel history keep their values, whatever the channel inputs carry.
- R9: `clr` high at a clock edge sets the generator, the shadow register and the history to zero, whatever `shift_en` is. `clr` takes priority over shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear at the start of a pattern |
| shift_en | input | 1 | Shift-cycle enable; all state is held when low |
| chan_in | input | 2 | Tester channel bits injected this cycle |
| incr_in | input | 8 | Incremental-pattern bit for each chain |
| parent_out | output | 8 | Parent-pattern bit for each chain |
| sel_out | output | 8 | Select for each chain (1 = incremental) |
| scan_out | output | 8 | Data into each scan chain |

## Verification
The hardest situation to reach from the ports is a long run of shift cycles in which the generator keeps changing under random channel data while the selects must stay frozen. Random channel bits give a reload about every other cycle, so such runs almost never occur by chance. The stimulus therefore chooses channel 1 in each cycle so that the parity over the current and kept bits comes out 0, while channel 0 stays random. It then places single forced reloads inside those runs and checks that the selects jump to the state from before the advance. Clears and frozen capture stretches are interleaved with these runs.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  // Phase-shifter tap mask: three XOR taps per output, offset by seed.
  // Coinciding taps cancel (XOR build), matching an XOR gate with a doubled input.
  function automatic logic [63:0] ps_mask(input int w, input int seed, input int j);
    logic [63:0] m;
    m = '0;
    m[(5*j + seed) % w]      = m[(5*j + seed) % w] ^ 1'b1;
    m[(11*j + 3 + seed) % w] = m[(11*j + 3 + seed) % w] ^ 1'b1;
    m[(17*j + 7 + seed) % w] = m[(17*j + 7 + seed) % w] ^ 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ssd_ring_gen.sv
module ssd_ring_gen #(
  parameter int          STATE_W = 32,
  parameter int          CH      = 2,
  parameter logic [STATE_W-1:0] TAPS = 32'h8020_0003,
  parameter logic [CH*8-1:0]    INJ_POS = {8'd17, 8'd5}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift_en,
  input  logic [CH-1:0]      chan,
  output logic [STATE_W-1:0] state
);
  logic [STATE_W-1:0] adv;
  logic [STATE_W-1:0] state_nx;

  always_comb begin
    adv = {state[STATE_W-2:0], ^(state & TAPS)};
    for (int c = 0; c < CH; c++) begin
      adv[INJ_POS[c*8 +: 8]] = adv[INJ_POS[c*8 +: 8]] ^ chan[c];
    end
  end

  always_comb begin
    state_nx = state;
    if (clr)           state_nx = '0;
    else if (shift_en) state_nx = adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_nx;
  end

  AST_RING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(state)); // R8
  AST_RING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == '0)); // R9
endmodule

// File: rtl/ssd_phase_shifter.sv
module ssd_phase_shifter #(
  parameter int STATE_W = 32,
  parameter int OUTS    = 8,
  parameter int SEED    = 0
) (
  input  logic [STATE_W-1:0] state,
  output logic [OUTS-1:0]    bits
);
  for (genvar j = 0; j < OUTS; j++) begin : g_out
    localparam logic [63:0] MASK = ssd_pkg::ps_mask(STATE_W, SEED, j);
    assign bits[j] = ^(state & MASK[STATE_W-1:0]);
  end
endmodule

// File: rtl/ssd_shadow_ctl.sv
module ssd_shadow_ctl #(
  parameter int STATE_W   = 32,
  parameter int CH        = 2,
  parameter int BUF_DEPTH = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift_en,
  input  logic [CH-1:0]      chan,
  input  logic [STATE_W-1:0] gen_state,
  output logic [STATE_W-1:0] shadow
);
  logic [BUF_DEPTH-1:0][CH-1:0] hist;
  logic [BUF_DEPTH-1:0][CH-1:0] hist_sh;
  logic [BUF_DEPTH-1:0][CH-1:0] hist_nx;
  logic [STATE_W-1:0]           shadow_nx;
  logic                         reload;

  assign hist_sh[0] = chan;
  for (genvar i = 1; i < BUF_DEPTH; i++) begin : g_hist
    assign hist_sh[i] = hist[i-1];
  end

  assign reload = (^chan) ^ (^hist);

  always_comb begin
    hist_nx   = hist;
    shadow_nx = shadow;
    if (clr) begin
      hist_nx   = '0;
      shadow_nx = '0;
    end else if (shift_en) begin
      hist_nx = hist_sh;
      if (reload) shadow_nx = gen_state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      shadow <= '0;
    end else begin
      hist   <= hist_nx;
      shadow <= shadow_nx;
    end
  end

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr && reload) |=> (shadow == $past(gen_state))); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr && !reload) |=> $stable(shadow)); // R6
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> ($stable(shadow) && $stable(hist))); // R8
  AST_SHADOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (shadow == '0 && hist == '0)); // R9
endmodule

// File: rtl/shadow_select_decomp.sv
module shadow_select_decomp #(
  parameter int STATE_W   = 32,
  parameter int CH        = 2,
  parameter int CHAINS    = 8,
  parameter int BUF_DEPTH = 1,
  parameter int SEL_SEED  = 13,
  parameter logic [STATE_W-1:0] TAPS    = 32'h8020_0003,
  parameter logic [CH*8-1:0]    INJ_POS = {8'd17, 8'd5}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [CH-1:0]     chan_in,
  input  logic [CHAINS-1:0] incr_in,
  output logic [CHAINS-1:0] parent_out,
  output logic [CHAINS-1:0] sel_out,
  output logic [CHAINS-1:0] scan_out
);
  logic [STATE_W-1:0] gen_state;
  logic [STATE_W-1:0] shadow;

  ssd_ring_gen #(.STATE_W(STATE_W), .CH(CH), .TAPS(TAPS), .INJ_POS(INJ_POS)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
    .chan(chan_in), .state(gen_state)
  );

  ssd_shadow_ctl #(.STATE_W(STATE_W), .CH(CH), .BUF_DEPTH(BUF_DEPTH)) u_shadow (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
    .chan(chan_in), .gen_state(gen_state), .shadow(shadow)
  );

  ssd_phase_shifter #(.STATE_W(STATE_W), .OUTS(CHAINS), .SEED(0)) u_ps_parent (
    .state(gen_state), .bits(parent_out)
  );

  ssd_phase_shifter #(.STATE_W(STATE_W), .OUTS(CHAINS), .SEED(SEL_SEED)) u_ps_sel (
    .state(shadow), .bits(sel_out)
  );

  for (genvar j = 0; j < CHAINS; j++) begin : g_mux
    assign scan_out[j] = sel_out[j] ? incr_in[j] : parent_out[j];
  end

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> ($stable(sel_out) && $stable(parent_out))); // R8
  AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sel_out == '0 && parent_out == '0)); // R9
endmodule

// File: tb/sim_shadow_select_decomp.sv
module sim_shadow_select_decomp;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic       shift_en;
  logic [1:0] chan_in;
  logic [7:0] incr_in;
  logic [7:0] parent_out, sel_out, scan_out;

  int total = 0;
  int bad   = 0;

  // reference model
  logic [31:0] m_st, m_sh;
  logic        m_hq[$];
  logic [7:0]  prev_sel;
  logic        held;

  always #2 clk = ~clk;

  shadow_select_decomp u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
    .chan_in(chan_in), .incr_in(incr_in),
    .parent_out(parent_out), .sel_out(sel_out), .scan_out(scan_out)
  );

  function automatic logic [7:0] ps(input logic [31:0] s, input int seed);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) begin
      r[j] = s[(5*j + seed) % 32] ^ s[(11*j + 3 + seed) % 32] ^ s[(17*j + 7 + seed) % 32];
    end
    return r;
  endfunction

  function automatic logic hist_par();
    logic p = 1'b0;
    foreach (m_hq[i]) p ^= m_hq[i];
    return p;
  endfunction

  task automatic model_clear();
    m_st = '0; m_sh = '0;
    m_hq.delete();
    m_hq.push_back(1'b0);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic se, input logic cl, input logic [1:0] ch);
    logic [7:0] exp_scan;
    logic       en;
    logic [31:0] nst;
    @(negedge clk);
    shift_en = se; clr = cl; chan_in = ch; incr_in = 8'($urandom);
    #1;
    chk("R3 parent", parent_out, ps(m_st, 0));
    chk("R5 select", sel_out, ps(m_sh, 13));
    if (held) chk("R6 hold", sel_out, prev_sel);
    for (int j = 0; j < 8; j++) exp_scan[j] = sel_out[j] ? incr_in[j] : parent_out[j];
    chk("R7 mux", scan_out, exp_scan);
    prev_sel = sel_out;
    en = ch[0] ^ ch[1] ^ hist_par();
    held = 1'b0;
    @(posedge clk);
    if (cl) begin
      model_clear();
    end else if (se) begin
      if (en) m_sh = m_st;
      else    held = 1'b1;
      nst = {m_st[30:0], ^(m_st & 32'h8020_0003)};
      nst[5]  ^= ch[0];
      nst[17] ^= ch[1];
      m_st = nst;
      m_hq.push_back(ch[0] ^ ch[1]);
      void'(m_hq.pop_front());
    end else begin
      held = 1'b1; // R8: frozen cycle keeps selects
    end
  endtask

  // channel pair giving reload parity 0 (hold) or 1 (load)
  function automatic logic [1:0] pick(input logic want);
    logic a = 1'($urandom);
    return {a ^ hist_par() ^ want, a};
  endfunction

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; shift_en = 1'b0; chan_in = '0; incr_in = '0;
    held = 1'b0; prev_sel = '0;
    model_clear();
    #1;
    chk("R1 reset parent", parent_out, 8'h00);
    chk("R1 reset sel", sel_out, 8'h00);
    chk("R1 reset scan", scan_out, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 release sel", sel_out, 8'h00);
    chk("R1 release parent", parent_out, 8'h00);

    // R2/R4: random channels
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 2'($urandom));
    // R6: long hold runs with single forced reloads (R5)
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < 25; i++) cyc(1'b1, 1'b0, pick(1'b0));
      cyc(1'b1, 1'b0, pick(1'b1));
    end
    // R8: capture stretch with toggling channels
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 2'($urandom));
    for (int i = 0; i < 50; i++) cyc(1'b1, 1'b0, 2'($urandom));
    // R9: clear with and without shift, then confirm zeros
    cyc(1'b1, 1'b1, 2'b11);
    @(negedge clk); #1;
    chk("R9 clear parent", parent_out, 8'h00);
    chk("R9 clear sel", sel_out, 8'h00);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 2'($urandom));
    cyc(1'b0, 1'b1, 2'b01);
    for (int i = 0; i < 200; i++) cyc($urandom_range(0, 3) != 0, 1'b0, 2'($urandom));
    for (int i = 0; i < 60; i++) cyc(1'b1, 1'b0, pick(1'b0));
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 2'($urandom));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule